// File: doc/BRIEF.md
# Weighted Two-Level Channel Arbiter

This block decides which of several DMA channels may drive a single shared data mover. All channels draw on one bandwidth budget, and the arbiter splits that budget. Each channel presents a request line, a one-bit priority class and a 4-bit weight. The arbiter divides the budget first by class and then, inside a class, in proportion to weight.

One channel holds the grant at a time. The data mover pulses a "unit done" signal each time it finishes a transfer unit for the holder. The holder keeps the grant for as many units as its weight. The grant then passes round-robin to the next requesting channel of the same class. A high-class request overrides the low class, but only at a unit boundary: a low-class holder is never cut off mid-unit. Configuration inputs are assumed static while a channel requests.

Top module: `wrr_chan_arb`

## Requirements
- R1: After reset the grant vector is all zeros. The first grant in each class goes to the lowest-numbered requesting channel of that class, because each class pointer resets to the last channel.
- R2: The grant vector is one-hot or all zeros at all times. Bit c of the grant vector means channel c holds the grant.
- R3: When no channel requests, the grant vector is all zeros from the next cycle on. A unit-done pulse while nothing is granted has no effect.
- R4: Whenever a new holder is chosen, a requesting channel whose priority bit is 1 (high class) is chosen over any channel whose priority bit is 0 (low class).
- R5: A holder with weight W keeps the grant through W unit-done pulses. After the W-th pulse, the grant goes in the next cycle to the next requesting channel of the same class, searching upward from the holder's index with wrap-around.
- R6: A weight of 0 behaves exactly like a weight of 1.
- R7: If the holder deasserts its request, the grant moves to another requesting channel, or to zero, in the next cycle. Its remaining credit is discarded, and a later grant to it starts with its full weight.
- R8: While the holder keeps requesting and no unit-done pulse arrives, the grant does not change, even if higher-class requests appear.
- R9: A unit-done pulse to a low-class holder while any high-class channel requests moves the grant to the high class in the next cycle, whatever credit the holder has left.
- R10: Each class keeps its round-robin pointer through idle periods. The search after an idle period starts after the last channel granted in that class.
- R11: When the holder's credit ends and it is the only requester of its class, and no higher class is requesting, it is granted again with fresh credit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NUM_CH | Per-channel request |
| hi_prio_i | input | NUM_CH | Per-channel class: 1 selects the high class |
| weight_i | input | NUM_CH*4 | Per-channel weight, channel c at bits [4c+3:4c] |
| unit_done_i | input | 1 | One-cycle pulse from the data mover at the end of a transfer unit |
| grant_o | output | NUM_CH | One-hot grant, all zeros when idle |

## Verification
The bench targets the points where the credit count, the class pointers and the preemption rule meet.

- Credit counting: it counts unit pulses through weights 2 and 3. A counter off by one would hand over the grant a pulse early or late.
- Zero weight: it drives a channel with weight 0. A design that loaded 0 as credit would hold that channel forever or wrap through 16 units.
- Early drop: it drops a holder's request mid-credit and later regrants it. Leftover credit would then show up as a shortened share.
- Idle retention: it idles the arbiter and checks that the next low-class grant resumes after the previous holder rather than at channel 0.
- Preemption timing: it raises a high-class request while a low-class channel holds the grant. A design that preempted before the unit boundary, or not at all, would move the grant at the wrong cycle.

// File: rtl/wrr_arb_pkg.sv
package wrr_arb_pkg;

    localparam int WGT_W = 4;

    typedef logic [WGT_W-1:0] weight_t;

    typedef enum logic {
        LVL_LO = 1'b0,
        LVL_HI = 1'b1
    } level_e;

    typedef enum logic [1:0] {
        ACT_HOLD   = 2'd0,
        ACT_COUNT  = 2'd1,
        ACT_SWITCH = 2'd2
    } action_e;

    // A configured weight of zero grants one unit so no channel starves.
    function automatic weight_t eff_weight(input weight_t w);
        return (w == '0) ? weight_t'(1) : w;
    endfunction

endpackage

// File: rtl/wrr_rr_pick.sv
module wrr_rr_pick #(
    parameter int NUM_CH = 6,
    parameter int IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [NUM_CH-1:0] cand_i,
    input  logic [IDX_W-1:0]  after_i,
    output logic              found_o,
    output logic [IDX_W-1:0]  idx_o
);
    // Search upward from after_i+1 with wrap-around; the closest hit wins.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int k = NUM_CH; k >= 1; k--) begin
            int j;
            j = int'(after_i) + k;
            if (j >= NUM_CH) j = j - NUM_CH;
            if (cand_i[j]) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(j);
            end
        end
    end
endmodule

// File: rtl/wrr_level.sv
module wrr_level #(
    parameter int NUM_CH = 6,
    parameter int IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] cand_i,
    input  logic              commit_i,
    input  logic [IDX_W-1:0]  commit_idx_i,
    output logic              found_o,
    output logic [IDX_W-1:0]  idx_o
);
    logic [IDX_W-1:0] last_q;

    // Pointer holds the last channel granted in this class; kept across idle.
    always_ff @(posedge clk) begin
        if (rst)           last_q <= IDX_W'(NUM_CH - 1);
        else if (commit_i) last_q <= commit_idx_i;
    end

    wrr_rr_pick #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_pick (
        .cand_i  (cand_i),
        .after_i (last_q),
        .found_o (found_o),
        .idx_o   (idx_o)
    );

    a_r10_ptr_valid: assert property (@(posedge clk) disable iff (rst)
        int'(last_q) < NUM_CH);

    a_r10_ptr_only_on_commit: assert property (@(posedge clk) disable iff (rst)
        !commit_i |=> $stable(last_q));
endmodule

// File: rtl/wrr_credit.sv
module wrr_credit
    import wrr_arb_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    load_i,
    input  weight_t load_val_i,
    input  logic    dec_i,
    output logic    last_o
);
    weight_t cnt_q;

    always_ff @(posedge clk) begin
        if (rst)         cnt_q <= '0;
        else if (load_i) cnt_q <= load_val_i;
        else if (dec_i)  cnt_q <= cnt_q - weight_t'(1);
    end

    assign last_o = (cnt_q == weight_t'(1));

    a_r6_load_nonzero: assert property (@(posedge clk) disable iff (rst)
        load_i |=> cnt_q != '0);

    a_r5_no_underflow: assert property (@(posedge clk) disable iff (rst)
        (dec_i && !load_i) |-> cnt_q > weight_t'(1));
endmodule

// File: rtl/wrr_chan_arb.sv
module wrr_chan_arb
    import wrr_arb_pkg::*;
#(
    parameter int NUM_CH = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM_CH-1:0]       req_i,
    input  logic [NUM_CH-1:0]       hi_prio_i,
    input  logic [NUM_CH*WGT_W-1:0] weight_i,
    input  logic                    unit_done_i,
    output logic [NUM_CH-1:0]       grant_o
);
    localparam int IDX_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int NUM_LVL = 2;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
        level_e           lvl;
    } holder_t;

    holder_t holder_q, holder_d;

    logic [NUM_LVL-1:0] lvl_found;
    logic [IDX_W-1:0]   lvl_idx [NUM_LVL];
    logic [NUM_LVL-1:0] lvl_commit;

    logic             credit_last;
    logic             credit_load;
    logic             credit_dec;
    weight_t          new_weight;
    logic [IDX_W-1:0] pick_idx;
    level_e           pick_lvl;
    logic             pick_found;
    logic             holder_live;
    logic             preempt;
    action_e          act;

    // One round-robin pointer and picker per class.
    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
        logic [NUM_CH-1:0] cand;
        assign cand = (l == int'(LVL_HI)) ? (req_i & hi_prio_i) : (req_i & ~hi_prio_i);

        wrr_level #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_level (
            .clk          (clk),
            .rst          (rst),
            .cand_i       (cand),
            .commit_i     (lvl_commit[l]),
            .commit_idx_i (pick_idx),
            .found_o      (lvl_found[l]),
            .idx_o        (lvl_idx[l])
        );
    end

    // Strict class order: high class first.
    always_comb begin
        pick_found = |lvl_found;
        pick_lvl   = lvl_found[LVL_HI] ? LVL_HI : LVL_LO;
        pick_idx   = lvl_found[LVL_HI] ? lvl_idx[LVL_HI] : lvl_idx[LVL_LO];
        new_weight = eff_weight(weight_i[pick_idx*WGT_W +: WGT_W]);
    end

    always_comb begin
        holder_live = holder_q.valid && req_i[holder_q.idx];
        preempt     = (holder_q.lvl == LVL_LO) && lvl_found[LVL_HI];
        if (!holder_live)
            act = ACT_SWITCH;
        else if (unit_done_i && (credit_last || preempt))
            act = ACT_SWITCH;
        else if (unit_done_i)
            act = ACT_COUNT;
        else
            act = ACT_HOLD;
    end

    always_comb begin
        holder_d    = holder_q;
        credit_load = 1'b0;
        credit_dec  = 1'b0;
        lvl_commit  = '0;
        unique case (act)
            ACT_SWITCH: begin
                if (pick_found) begin
                    holder_d.valid       = 1'b1;
                    holder_d.idx         = pick_idx;
                    holder_d.lvl         = pick_lvl;
                    credit_load          = 1'b1;
                    lvl_commit[pick_lvl] = 1'b1;
                end else begin
                    holder_d.valid = 1'b0;
                end
            end
            ACT_COUNT: credit_dec = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) holder_q <= '{valid: 1'b0, idx: '0, lvl: LVL_LO};
        else     holder_q <= holder_d;
    end

    wrr_credit u_credit (
        .clk        (clk),
        .rst        (rst),
        .load_i     (credit_load),
        .load_val_i (new_weight),
        .dec_i      (credit_dec),
        .last_o     (credit_last)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_gnt
        assign grant_o[c] = holder_q.valid && (holder_q.idx == IDX_W'(c));
    end

    a_r2_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_o));

    a_r3_idle_zero: assert property (@(posedge clk) disable iff (rst)
        (req_i == '0) |=> (grant_o == '0));

    a_r8_hold_stable: assert property (@(posedge clk) disable iff (rst)
        ((grant_o & req_i) != '0 && !unit_done_i) |=> $stable(grant_o));

    a_r4_idle_picks_high: assert property (@(posedge clk) disable iff (rst)
        (grant_o == '0 && (req_i & hi_prio_i) != '0) |=> (grant_o & hi_prio_i) != '0);

    a_r7_drop_moves: assert property (@(posedge clk) disable iff (rst)
        ((grant_o != '0) && (grant_o & req_i) == '0) |=> (grant_o != $past(grant_o)));
endmodule

// File: tb/tb_wrr_chan_arb.sv
module tb_wrr_chan_arb;
    localparam int N = 6;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] req = '0;
    logic [N-1:0] prio = 6'b110000;
    // weights ch5..ch0 = 2,1,1,0,3,2
    logic [N*4-1:0] wgt = 24'h211032;
    logic         done = 1'b0;
    logic [N-1:0] grant;

    int n_cmp = 0;
    int n_bad = 0;
    logic [N-1:0] exp_q [$];
    string        tag_q [$];
    bit           drv_done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    wrr_chan_arb #(.NUM_CH(N)) dut (
        .clk         (clk),
        .rst         (rst),
        .req_i       (req),
        .hi_prio_i   (prio),
        .weight_i    (wgt),
        .unit_done_i (done),
        .grant_o     (grant)
    );

    // Driver: apply inputs for one cycle, queue the grant expected after the edge.
    task automatic cyc(input logic [N-1:0] r, input logic d,
                       input logic [N-1:0] e, input string tag);
        @(negedge clk);
        req  = r;
        done = d;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // Monitor: compare just after each edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [N-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_cmp++;
                if (grant !== e) begin
                    n_bad++;
                    $display("FAIL %s: grant=%b expected=%b", t, grant, e);
                end
            end
        end
    end

    initial begin
        int cnt = 0;
        while (!drv_done && cnt < 5000) begin
            @(posedge clk);
            cnt++;
        end
        if (!drv_done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        n_cmp++;
        if (grant !== '0) begin
            n_bad++;
            $display("FAIL R1 reset: grant=%b expected=%b", grant, 6'b0);
        end
        rst = 1'b0;

        cyc(6'b000000, 0, 6'b000000, "R3 idle after reset");
        cyc(6'b000011, 0, 6'b000001, "R1 first low grant ch0");
        cyc(6'b000011, 0, 6'b000001, "R8 stable without done");
        cyc(6'b000011, 1, 6'b000001, "R5 ch0 unit 1 of 2");
        cyc(6'b000011, 0, 6'b000001, "R8 stable between units");
        cyc(6'b000011, 1, 6'b000010, "R5 ch0 credit end to ch1");
        cyc(6'b000011, 1, 6'b000010, "R5 ch1 unit 1 of 3");
        cyc(6'b000011, 1, 6'b000010, "R5 ch1 unit 2 of 3");
        cyc(6'b000011, 1, 6'b000001, "R5 wrap to ch0");
        cyc(6'b000010, 0, 6'b000010, "R7 ch0 drops, moves to ch1");
        cyc(6'b000011, 1, 6'b000010, "R7 ch1 unit 1");
        cyc(6'b000011, 1, 6'b000010, "R7 ch1 unit 2");
        cyc(6'b000011, 1, 6'b000001, "R7 back to ch0");
        cyc(6'b000011, 1, 6'b000001, "R7 ch0 fresh credit of 2");
        cyc(6'b000100, 0, 6'b000100, "R6 ch2 weight 0 granted");
        cyc(6'b000110, 1, 6'b000010, "R6 weight 0 gives one unit");
        cyc(6'b010110, 0, 6'b000010, "R8 no preempt without done");
        cyc(6'b010110, 1, 6'b010000, "R9 preempt to high ch4");
        cyc(6'b010110, 1, 6'b010000, "R11 sole high regrant");
        cyc(6'b110110, 1, 6'b100000, "R4 high rr to ch5");
        cyc(6'b000110, 0, 6'b000100, "R4 low resumes at ch2");
        cyc(6'b000000, 0, 6'b000000, "R3 idle zero");
        cyc(6'b000000, 0, 6'b000000, "R3 idle zero again");
        cyc(6'b001011, 0, 6'b001000, "R10 pointer kept, ch3");
        cyc(6'b001011, 1, 6'b000001, "R5 ch3 to ch0 skip high ch4/5");
        cyc(6'b000000, 0, 6'b000000, "R3 idle");
        cyc(6'b110001, 0, 6'b010000, "R4 high over low from idle");
        cyc(6'b110001, 0, 6'b010000, "R8 holder stable");
        cyc(6'b000000, 0, 6'b000000, "R3 release");
        cyc(6'b000000, 1, 6'b000000, "R3 done while idle ignored");

        repeat (3) @(negedge clk);
        drv_done = 1'b1;
    end
endmodule